// File: doc/BRIEF.md
# Three-Wire Serial Non-Volatile Memory Model

This block is a synthesizable model of a 1 Kbit serially accessed non-volatile memory, seen from its four pins: chip select, serial clock, serial data in and serial data out. A host raises chip select and then shifts in a frame, most significant bit first. The frame is a start bit, a two-bit opcode and an address, followed by a data word for the commands that need one. The model keeps the whole array in flip-flops. It supports reading a word, writing a word, erasing a word, erasing the whole array, filling the whole array with one value, and setting or clearing a modify-enable latch.

The serial pins are oversampled by the system clock, and every serial edge is found by comparing each pin with its value one clock earlier. The modifying commands start a self-timed programming interval. Its length is a parameter counted in system clocks. While it runs, new instructions are refused, and the data-out pin reports busy or ready whenever chip select is high. A configuration input selects one of two views of the same storage: 16-bit words or 8-bit bytes.

Top module: `mw_eeprom`

## Requirements
- R1: With `org16`=1 the array is 64 words of 16 bits, addressed by 6 bits. With `org16`=0 it is 128 bytes, addressed by 7 bits. Byte address bit 0 = 1 selects bits 15:8 and bit 0 = 0 selects bits 7:0 of the 16-bit word at byte address bits 6:1. After reset every bit is 1 and the enable latch is clear.
- R2: While `cs` is high, each rising edge of `sclk` samples `din`. The sampled 0s that come before the first sampled 1 are skipped. That 1 is the start bit. Two opcode bits follow, then the address, all MSB first.
- R3: Opcode 10 reads. On the edge that samples the last address bit, `dout_oe` goes to 1 and `dout` goes to 0 as a dummy bit. Each following `sclk` rising edge presents the next data bit, MSB first (16 bits or 8 bits). After the last data bit, `dout` is 0.
- R4: Opcode 01 writes. The address is followed by 16 data bits, or 8 in byte mode. Programming starts on the clock where `cs` is seen low after the last data bit.
- R5: Opcode 11 erases the addressed word or byte to all ones on the next `cs` fall. Other locations are left unchanged.
- R6: Opcode 00 is an extended command selected by the top two address bits. With 11 the enable latch is set, and with 00 it is cleared. Neither case starts a programming interval.
- R7: Extended 10 sets the whole array to ones. Extended 01 takes a data field and writes it into every word. In byte mode it writes the byte into every byte.
- R8: Write, erase, erase-all and fill-all do nothing while the enable latch is clear. The latch is cleared at reset and by the disable command.
- R9: A programming interval lasts exactly `PROG_CYCLES` clocks and starts on the clock after the terminating `cs` fall. A frame whose `cs` rise is sampled during the interval is ignored until `cs` falls.
- R10: After an interval has started, raising `cs` drives `dout_oe`=1 with `dout`=0 while busy and `dout`=1 once ready. This status output ends at the next accepted start bit, or at a `cs` fall while not busy.
- R11: While `cs` is low, `dout_oe` is 0.
- R12: Once a non-read frame is complete, further `sclk` edges are ignored until `cs` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock; its rising edges sample `din` |
| din | input | 1 | Serial command, address and data input |
| org16 | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| dout | output | 1 | Serial read data or ready/busy status |
| dout_oe | output | 1 | Output enable for `dout`; 0 models high impedance |

## Verification
Two functions can fall in the same clock: the programming timer reaching zero, and the sampled `cs` rise that decides whether a new frame is accepted. The bench provokes this by starting a write and then raising `cs` at a range of offsets around the end of the interval. Each such raise is followed by a complete write frame and a read-back. A behavioural model, built from bit queues and integer counters, predicts `dout_oe` and `dout` on every clock. Any disagreement in which cycle a frame is refused or accepted therefore shows up as a per-cycle mismatch and as a differing read-back value.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    // Modifying operation handed from the serial front end to the array
    typedef enum logic [2:0] {
        PK_NONE  = 3'd0,
        PK_WRITE = 3'd1,
        PK_ERASE = 3'd2,
        PK_ERAL  = 3'd3,
        PK_WRAL  = 3'd4
    } prog_kind_e;

    // Frame reception phases
    typedef enum logic [2:0] {
        FE_IDLE  = 3'd0,
        FE_OPC   = 3'd1,
        FE_ADDR  = 3'd2,
        FE_DATA  = 3'd3,
        FE_RDOUT = 3'd4,
        FE_DONE  = 3'd5
    } fe_state_e;

endpackage

// File: rtl/mw_store.sv
module mw_store
    import mw_eeprom_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int WORDS       = 64,
    parameter int PROG_CYCLES = 40,
    localparam int AW_W  = $clog2(WORDS),
    localparam int AW_B  = AW_W + 1,
    localparam int HB    = WORD_W / 2,
    localparam int TIM_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              org16,
    input  logic [AW_B-1:0]   rd_addr,
    output logic [WORD_W-1:0] rd_word,
    input  logic              prog_start,
    input  prog_kind_e        prog_kind,
    input  logic [AW_B-1:0]   prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    output logic              busy
);

    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] mem;
        logic [TIM_W-1:0]             timer;
    } st_t;

    st_t q, d;
    logic [WORD_W-1:0] wval;
    logic [WORD_W-1:0] sel_word;

    assign wval = (prog_kind == PK_ERASE) ? {WORD_W{1'b1}} : prog_data;

    always_comb begin
        d = q;
        if (q.timer != '0) d.timer = q.timer - 1'b1;
        if (prog_start) begin
            d.timer = TIM_W'(PROG_CYCLES);
            case (prog_kind)
                PK_WRITE, PK_ERASE: begin
                    if (org16)
                        d.mem[prog_addr[AW_W-1:0]] = wval;
                    else if (prog_addr[0])
                        d.mem[prog_addr[AW_B-1:1]][WORD_W-1:HB] = wval[HB-1:0];
                    else
                        d.mem[prog_addr[AW_B-1:1]][HB-1:0] = wval[HB-1:0];
                end
                PK_ERAL: d.mem = '1;
                PK_WRAL: begin
                    for (int i = 0; i < WORDS; i++)
                        d.mem[i] = org16 ? prog_data : {2{prog_data[HB-1:0]}};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mem   <= '1;
            q.timer <= '0;
        end else begin
            q <= d;
        end
    end

    // Combinational read port, byte lane picked in 8-bit view
    always_comb begin
        sel_word = org16 ? q.mem[rd_addr[AW_W-1:0]] : q.mem[rd_addr[AW_B-1:1]];
        if (org16)
            rd_word = sel_word;
        else if (rd_addr[0])
            rd_word = {{HB{1'b0}}, sel_word[WORD_W-1:HB]};
        else
            rd_word = {{HB{1'b0}}, sel_word[HB-1:0]};
    end

    assign busy = (q.timer != '0);

endmodule

// File: rtl/mw_frontend.sv
module mw_frontend
    import mw_eeprom_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int WORDS  = 64,
    localparam int AW_W  = $clog2(WORDS),
    localparam int AW_B  = AW_W + 1,
    localparam int HB    = WORD_W / 2,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sclk,
    input  logic              din,
    input  logic              org16,
    input  logic              busy,
    input  logic [WORD_W-1:0] rd_word,
    output logic [AW_B-1:0]   rd_addr,
    output logic              prog_start,
    output prog_kind_e        prog_kind,
    output logic [AW_B-1:0]   prog_addr,
    output logic [WORD_W-1:0] prog_data,
    output logic              dout,
    output logic              dout_oe
);

    typedef struct packed {
        fe_state_e         st;
        logic [1:0]        op;
        logic [AW_B-1:0]   addr;
        logic [WORD_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
        logic              sclk_q;
        logic              cs_q;
        logic              armed;
        logic              en;
        logic              status;
        logic              rd_on;
        logic              dout_bit;
        logic [WORD_W-1:0] rd_sr;
        prog_kind_e        pend;
        logic [AW_B-1:0]   pend_addr;
        logic [WORD_W-1:0] pend_data;
    } fe_t;

    fe_t q, d;

    logic             cs_rise, cs_fall, sck_up;
    logic [AW_B-1:0]  a_full;
    logic [1:0]       ext_sel;
    logic [CNT_W-1:0] aw_last, dw_last, dw_len;

    assign cs_rise = cs & ~q.cs_q;
    assign cs_fall = ~cs & q.cs_q;
    assign sck_up  = sclk & ~q.sclk_q;
    assign a_full  = {q.addr[AW_B-2:0], din};
    assign ext_sel = org16 ? a_full[AW_W-1:AW_W-2] : a_full[AW_B-1:AW_B-2];
    assign aw_last = org16 ? CNT_W'(AW_W - 1) : CNT_W'(AW_B - 1);
    assign dw_last = org16 ? CNT_W'(WORD_W - 1) : CNT_W'(HB - 1);
    assign dw_len  = org16 ? CNT_W'(WORD_W) : CNT_W'(HB);
    assign rd_addr = a_full;

    always_comb begin
        d          = q;
        prog_start = 1'b0;
        d.sclk_q   = sclk;
        d.cs_q     = cs;
        if (cs_rise) d.armed = ~busy;

        if (cs_fall) begin
            d.st    = FE_IDLE;
            d.rd_on = 1'b0;
            d.armed = 1'b0;
            if (q.pend != PK_NONE && q.en) begin
                prog_start = 1'b1;
                d.status   = 1'b1;
            end else if (!busy) begin
                d.status = 1'b0;
            end
            d.pend = PK_NONE;
        end else if (cs && q.armed && sck_up) begin
            case (q.st)
                FE_IDLE: begin
                    if (din) begin
                        d.st     = FE_OPC;
                        d.cnt    = '0;
                        d.status = 1'b0;
                    end
                end
                FE_OPC: begin
                    d.op = {q.op[0], din};
                    if (q.cnt == CNT_W'(1)) begin
                        d.st   = FE_ADDR;
                        d.cnt  = '0;
                        d.addr = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                FE_ADDR: begin
                    d.addr = a_full;
                    if (q.cnt == aw_last) begin
                        d.cnt = '0;
                        case (q.op)
                            2'b10: begin
                                d.rd_sr    = rd_word;
                                d.rd_on    = 1'b1;
                                d.dout_bit = 1'b0;
                                d.st       = FE_RDOUT;
                            end
                            2'b01: begin
                                d.st   = FE_DATA;
                                d.data = '0;
                            end
                            2'b11: begin
                                d.pend      = PK_ERASE;
                                d.pend_addr = a_full;
                                d.st        = FE_DONE;
                            end
                            default: begin
                                d.st = FE_DONE;
                                case (ext_sel)
                                    2'b11: d.en   = 1'b1;
                                    2'b00: d.en   = 1'b0;
                                    2'b10: d.pend = PK_ERAL;
                                    default: begin
                                        d.st   = FE_DATA;
                                        d.data = '0;
                                    end
                                endcase
                            end
                        endcase
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                FE_DATA: begin
                    d.data = {q.data[WORD_W-2:0], din};
                    if (q.cnt == dw_last) begin
                        d.pend      = (q.op == 2'b01) ? PK_WRITE : PK_WRAL;
                        d.pend_addr = q.addr;
                        d.pend_data = {q.data[WORD_W-2:0], din};
                        d.st        = FE_DONE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                FE_RDOUT: begin
                    if (q.cnt < dw_len) begin
                        d.dout_bit = org16 ? q.rd_sr[WORD_W-1] : q.rd_sr[HB-1];
                        d.rd_sr    = {q.rd_sr[WORD_W-2:0], 1'b0};
                        d.cnt      = q.cnt + 1'b1;
                    end else begin
                        d.dout_bit = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= FE_IDLE;
            q.op        <= '0;
            q.addr      <= '0;
            q.data      <= '0;
            q.cnt       <= '0;
            q.sclk_q    <= 1'b0;
            q.cs_q      <= 1'b0;
            q.armed     <= 1'b0;
            q.en        <= 1'b0;
            q.status    <= 1'b0;
            q.rd_on     <= 1'b0;
            q.dout_bit  <= 1'b0;
            q.rd_sr     <= '0;
            q.pend      <= PK_NONE;
            q.pend_addr <= '0;
            q.pend_data <= '0;
        end else begin
            q <= d;
        end
    end

    assign prog_kind = q.pend;
    assign prog_addr = q.pend_addr;
    assign prog_data = q.pend_data;
    assign dout_oe   = cs & (q.status | q.rd_on);
    assign dout      = q.status ? ~busy : q.dout_bit;

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_eeprom_pkg::*;
#(
    parameter int MEM_BITS    = 1024,
    parameter int WORD_W      = 16,
    parameter int PROG_CYCLES = 40,
    localparam int WORDS = MEM_BITS / WORD_W,
    localparam int AW_W  = $clog2(WORDS),
    localparam int AW_B  = AW_W + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sclk,
    input  logic din,
    input  logic org16,
    output logic dout,
    output logic dout_oe
);

    logic [AW_B-1:0]   rd_addr_w;
    logic [WORD_W-1:0] rd_word_w;
    logic              prog_start_w;
    prog_kind_e        prog_kind_w;
    logic [AW_B-1:0]   prog_addr_w;
    logic [WORD_W-1:0] prog_data_w;
    logic              busy_w;

    mw_frontend #(
        .WORD_W (WORD_W),
        .WORDS  (WORDS)
    ) fe_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs         (cs),
        .sclk       (sclk),
        .din        (din),
        .org16      (org16),
        .busy       (busy_w),
        .rd_word    (rd_word_w),
        .rd_addr    (rd_addr_w),
        .prog_start (prog_start_w),
        .prog_kind  (prog_kind_w),
        .prog_addr  (prog_addr_w),
        .prog_data  (prog_data_w),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );

    mw_store #(
        .WORD_W      (WORD_W),
        .WORDS       (WORDS),
        .PROG_CYCLES (PROG_CYCLES)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .org16      (org16),
        .rd_addr    (rd_addr_w),
        .rd_word    (rd_word_w),
        .prog_start (prog_start_w),
        .prog_kind  (prog_kind_w),
        .prog_addr  (prog_addr_w),
        .prog_data  (prog_data_w),
        .busy       (busy_w)
    );

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
    parameter int PROG_CYCLES = 40
) (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic dout,
    input logic dout_oe,
    input logic busy
);

    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    AST_HIZ_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !dout_oe);                                  // R11

    AST_BUSY_SHOWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && dout_oe && busy) |-> !dout);                 // R10

    AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == PROG_CYCLES));         // R9

    AST_PROG_AFTER_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!$past(cs) && $past(cs, 2)));      // R4

endmodule

bind mw_eeprom mw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .dout    (dout),
    .dout_oe (dout_oe),
    .busy    (busy_w)
);

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, din = 1'b0, org16 = 1'b1;
    logic dout, dout_oe;

    int compared = 0;
    int mismatched = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mw_eeprom #(.MEM_BITS(1024), .WORD_W(16), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
        .org16(org16), .dout(dout), .dout_oe(dout_oe)
    );

    // ---------------- behavioural reference model ----------------
    logic [15:0] mm [64];
    int  m_busy, m_pk, m_pa, m_pd;
    bit  m_csp, m_sckp, m_armed, m_en, m_status, m_rd, m_coll, m_done, m_dout;
    bit  bq[$];
    bit  rq[$];

    function automatic int m_read(int a);
        if (org16) return int'(mm[a]);
        if (a % 2 == 1) return int'(mm[a / 2][15:8]);
        return int'(mm[a / 2][7:0]);
    endfunction

    task automatic m_apply();
        logic [15:0] v;
        v = (m_pk == 2) ? 16'hFFFF : 16'(m_pd);
        case (m_pk)
            1, 2: begin
                if (org16) mm[m_pa] = v;
                else if (m_pa % 2 == 1) mm[m_pa / 2][15:8] = v[7:0];
                else mm[m_pa / 2][7:0] = v[7:0];
            end
            3: foreach (mm[i]) mm[i] = 16'hFFFF;
            4: foreach (mm[i]) mm[i] = org16 ? v : {v[7:0], v[7:0]};
            default: ;
        endcase
    endtask

    task automatic m_reset();
        foreach (mm[i]) mm[i] = 16'hFFFF;
        m_busy = 0; m_pk = 0; m_pa = 0; m_pd = 0;
        m_csp = 0; m_sckp = 0; m_armed = 0; m_en = 0; m_status = 0;
        m_rd = 0; m_coll = 0; m_done = 0; m_dout = 0;
        bq.delete(); rq.delete();
    endtask

    initial m_reset();

    always @(posedge clk) begin
        int nb, aw, dw, n, a, op, v;
        bit bsy, old_armed;
        if (!rst_n) begin
            m_reset();
        end else begin
            bsy = (m_busy > 0);
            nb = bsy ? m_busy - 1 : 0;
            old_armed = m_armed;
            aw = org16 ? 6 : 7;
            dw = org16 ? 16 : 8;
            if (cs && !m_csp) m_armed = !bsy;
            if (!cs && m_csp) begin
                if (m_pk != 0 && m_en) begin
                    m_apply(); nb = PROG; m_status = 1;
                end else if (!bsy) m_status = 0;
                m_pk = 0; m_armed = 0; m_rd = 0; m_coll = 0; m_done = 0;
            end else if (cs && old_armed && sclk && !m_sckp) begin
                if (m_rd) begin
                    m_dout = (rq.size() > 0) ? rq.pop_front() : 1'b0;
                end else if (m_coll) begin
                    bq.push_back(din);
                    n = bq.size();
                    op = 2 * int'(bq[0]) + int'(bq[1]);
                    a = 0;
                    for (int i = 0; i < aw && i + 2 < n; i++) a = 2 * a + int'(bq[2 + i]);
                    if (n == 2 + aw) begin
                        if (op == 2) begin
                            v = m_read(a);
                            rq.delete();
                            for (int i = dw - 1; i >= 0; i--) rq.push_back(v[i]);
                            m_dout = 0; m_rd = 1; m_coll = 0;
                        end else if (op == 3) begin
                            m_pk = 2; m_pa = a; m_coll = 0; m_done = 1;
                        end else if (op == 0) begin
                            case ((a >> (aw - 2)) & 3)
                                3: begin m_en = 1; m_coll = 0; m_done = 1; end
                                0: begin m_en = 0; m_coll = 0; m_done = 1; end
                                2: begin m_pk = 3; m_coll = 0; m_done = 1; end
                                default: ;
                            endcase
                        end
                    end else if (n == 2 + aw + dw) begin
                        v = 0;
                        for (int i = 0; i < dw; i++) v = 2 * v + int'(bq[2 + aw + i]);
                        m_pd = v; m_pa = a; m_pk = (op == 1) ? 1 : 4;
                        m_coll = 0; m_done = 1;
                    end
                end else if (!m_done && din) begin
                    m_coll = 1; bq.delete(); m_status = 0;
                end
            end
            m_busy = nb;
            m_csp = cs;
            m_sckp = sclk;
        end
    end

    // ---------------- checks ----------------
    task automatic chk(bit ok, string req, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison with the model (R3, R10, R11)
    always begin
        bit eoe, edo;
        @(negedge clk);
        #1;
        if (rst_n && !done_flag) begin
            eoe = cs && (m_status || m_rd);
            edo = m_status ? (m_busy == 0) : m_dout;
            chk(dout_oe === eoe, "R11/R10 per-cycle dout_oe", int'(dout_oe), int'(eoe));
            if (eoe) chk(dout === edo, "R3/R10 per-cycle dout", int'(dout), int'(edo));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cs_up();
        @(negedge clk) cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk) begin sclk = 1'b0; cs = 1'b0; end
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse(bit b);
        @(negedge clk) begin din = b; sclk = 1'b0; end
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic shift(int v, int nbits);
        for (int i = nbits - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic frame(int op, int a, int aw, int dval, int dw);
        cs_up();
        pulse(1'b1);
        shift(op, 2);
        shift(a, aw);
        if (dw > 0) shift(dval, dw);
        cs_down();
        repeat (PROG + 4) @(negedge clk);
    endtask

    task automatic do_read(int a, int lead0, output int val);
        int aw, dw;
        aw = org16 ? 6 : 7;
        dw = org16 ? 16 : 8;
        val = 0;
        cs_up();
        for (int i = 0; i < lead0; i++) pulse(1'b0);
        pulse(1'b1);
        shift(2, 2);
        shift(a, aw);
        #1;
        chk(dout_oe === 1'b1 && dout === 1'b0, "R3 dummy bit", int'(dout), 0);
        for (int i = 0; i < dw; i++) begin
            pulse(1'b0);
            #1;
            val = 2 * val + int'(dout);
        end
        cs_down();
    endtask

    // ---------------- test sequence ----------------
    initial begin
        int v;
        repeat (5) @(negedge clk);
        chk(dout_oe === 1'b0, "R11 reset dout_oe", int'(dout_oe), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        do_read(0, 0, v);
        chk(v == 16'hFFFF, "R1 reset contents", v, 16'hFFFF);

        // write while the enable latch is clear
        frame(1, 3, 6, 16'h1234, 16);
        do_read(3, 0, v);
        chk(v == 16'hFFFF, "R8 write without enable", v, 16'hFFFF);

        // enable, write, watch status
        frame(0, 6'b110000, 6, 0, 0);
        cs_up();
        pulse(1'b1); shift(1, 2); shift(5, 6); shift(16'hA5C3, 16);
        cs_down();
        cs_up();
        #1;
        chk(dout_oe === 1'b1 && dout === 1'b0, "R10 busy shown", int'(dout), 0);
        repeat (PROG) @(negedge clk);
        #1;
        chk(dout_oe === 1'b1 && dout === 1'b1, "R10 ready shown", int'(dout), 1);
        cs_down();
        do_read(5, 3, v);
        chk(v == 16'hA5C3, "R4 R2 write then read with leading zeros", v, 16'hA5C3);

        // instruction during busy is ignored
        cs_up();
        pulse(1'b1); shift(1, 2); shift(7, 6); shift(16'h1111, 16);
        cs_down();
        cs_up();
        pulse(1'b1); shift(1, 2); shift(7, 6); shift(16'h2222, 16);
        cs_down();
        repeat (PROG + 4) @(negedge clk);
        do_read(7, 0, v);
        chk(v == 16'h1111, "R9 frame during busy ignored", v, 16'h1111);

        // erase with trailing extra bits
        cs_up();
        pulse(1'b1); shift(3, 2); shift(5, 6);
        pulse(1'b1); pulse(1'b0); pulse(1'b1);
        cs_down();
        repeat (PROG + 4) @(negedge clk);
        do_read(5, 0, v);
        chk(v == 16'hFFFF, "R5 R12 erase word", v, 16'hFFFF);
        do_read(7, 0, v);
        chk(v == 16'h1111, "R5 neighbour untouched", v, 16'h1111);

        // byte view
        org16 = 1'b0;
        frame(1, 9, 7, 8'h3C, 8);
        do_read(9, 0, v);
        chk(v == 8'h3C, "R1 byte write", v, 8'h3C);
        do_read(8, 0, v);
        chk(v == 8'hFF, "R1 other byte lane", v, 8'hFF);
        org16 = 1'b1;
        do_read(4, 0, v);
        chk(v == 16'h3CFF, "R1 byte lane placement", v, 16'h3CFF);

        // fill-all and erase-all
        frame(0, 6'b010000, 6, 16'h5A5A, 16);
        do_read(0, 0, v);
        chk(v == 16'h5A5A, "R7 fill-all low", v, 16'h5A5A);
        do_read(63, 0, v);
        chk(v == 16'h5A5A, "R7 fill-all high", v, 16'h5A5A);
        frame(0, 6'b100000, 6, 0, 0);
        do_read(0, 0, v);
        chk(v == 16'hFFFF, "R7 erase-all low", v, 16'hFFFF);
        do_read(63, 0, v);
        chk(v == 16'hFFFF, "R7 erase-all high", v, 16'hFFFF);
        org16 = 1'b0;
        frame(0, 7'b0100000, 7, 8'h96, 8);
        org16 = 1'b1;
        do_read(20, 0, v);
        chk(v == 16'h9696, "R7 byte fill-all", v, 16'h9696);

        // disable blocks writes
        frame(0, 6'b000000, 6, 0, 0);
        frame(1, 2, 6, 16'h0F0F, 16);
        do_read(2, 0, v);
        chk(v == 16'h9696, "R6 R8 disable blocks write", v, 16'h9696);
        frame(3, 2, 6, 0, 0);
        do_read(2, 0, v);
        chk(v == 16'h9696, "R8 disable blocks erase", v, 16'h9696);

        // cs rise swept around the end of the programming interval
        frame(0, 6'b110000, 6, 0, 0);
        for (int off = PROG - 4; off <= PROG + 1; off++) begin
            cs_up();
            pulse(1'b1); shift(1, 2); shift(10, 6); shift(16'h0100 + off, 16);
            cs_down();
            repeat (off - 2) @(negedge clk);
            cs_up();
            pulse(1'b1); shift(1, 2); shift(11, 6); shift(16'h0200 + off, 16);
            cs_down();
            repeat (PROG + 4) @(negedge clk);
            do_read(11, 0, v);
            chk(v == m_read(11), "R9 sweep read-back", v, m_read(11));
        end

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule